// File: doc/BRIEF.md
# Real-Time Instruction Timeline Sequencer

The sequencer takes real-time instructions from a queue and runs them on a timeline that has no gaps. One clock cycle stands for one nanosecond. Every instruction carries a duration, and that duration counts from the cycle in which the instruction is accepted. The next instruction is accepted in exactly the cycle its predecessor's duration runs out. Output strobes for playback and acquisition therefore follow a schedule that is fixed in advance, and one waveform or acquisition can still be active when the next one is issued.

The first accepted instruction starts the timeline. After that the queue has to keep up. If no instruction is ready in the cycle it is due, the sequencer halts at once and raises a fault flag. It never stretches the timeline to wait for the producer. The only instructions that may hold the timeline are the two blocking waits: one waits for a trigger on a chosen network address, the other waits for the external sync-complete input. A condition input can suppress an instruction. A suppressed instruction issues nothing and only spends the else-duration supplied with it.

Top module: `rt_timeline`

## Requirements
- R1: After reset, running, error and every strobe are 0. With the sequencer idle, an instruction presented with instr_valid is accepted in that same cycle (instr_ready high), and running reads 1 from the next cycle on.
- R2: With a duration D of at least 4, the next instruction is accepted exactly D cycles after the current one.
- R3: A duration or else-duration below 4 (including 0) is handled as 4.
- R4: Opcode encoding: 1 update, 2 play, 3 square acquire, 4 weighted acquire, 5 TTL acquire, 6 timed wait, 7 trigger wait, 8 sync wait, 9 stop. Opcodes 1 to 5, when executed, pulse upd_stb for one cycle, in the cycle after acceptance.
- R5: Each executed play pulses play_stb in that same cycle, with play_idx0 = instr_arg0 and play_idx1 = instr_arg1 as they were at acceptance. Every play restarts playback, even when the previous one is still running.
- R6: Each executed acquire (opcodes 3 to 5) pulses acq_stb with acq_idx = instr_arg0 and acq_bin = instr_arg1. acq_kind is 0 for square, 1 for weighted and 2 for TTL.
- R7: A trigger wait (address in the low TADDR_W bits of instr_arg0) ignores triggers on other addresses. When trig_valid arrives with a matching trig_addr in cycle E, the next instruction is accepted in cycle E + D.
- R8: A sync wait blocks until sync_done is high in some cycle E. The next instruction is then accepted in cycle E + D.
- R9: When cond_pass is 0 at acceptance, the instruction issues no strobe, does not block, and does not stop. The next instruction is accepted after the else-duration.
- R10: If no instruction is valid in the cycle the current duration expires, and the current instruction is not a stop, error rises in the next cycle and running falls. error then stays high until reset, and no further instruction is accepted and no strobe is issued.
- R11: An executed stop keeps running high for its full duration. running drops in the next cycle without raising error, and the sequencer returns to idle.
- R12: Timed waits, trigger waits, sync waits, stops and unassigned opcodes issue no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per nanosecond |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Queue head holds an instruction |
| instr_ready | output | 1 | Head instruction is accepted this cycle |
| instr_op | input | 4 | Opcode |
| instr_arg0 | input | IDX_W | Wave-0 / acquisition index / trigger address |
| instr_arg1 | input | IDX_W | Wave-1 index / acquisition bin |
| instr_dur | input | DUR_W | Duration in cycles |
| cond_pass | input | 1 | Condition result for the head instruction |
| cond_else_dur | input | DUR_W | Duration spent when the instruction is suppressed |
| trig_valid | input | 1 | Trigger present on the network |
| trig_addr | input | TADDR_W | Address of that trigger |
| sync_done | input | 1 | Sync completed across sequencers |
| upd_stb | output | 1 | Latched-parameter update pulse |
| play_stb | output | 1 | Playback start pulse |
| play_idx0 | output | IDX_W | Waveform index for path 0 |
| play_idx1 | output | IDX_W | Waveform index for path 1 |
| acq_stb | output | 1 | Acquisition start pulse |
| acq_idx | output | IDX_W | Acquisition index |
| acq_bin | output | IDX_W | Bin index |
| acq_kind | output | 2 | 0 square, 1 weighted, 2 TTL |
| running | output | 1 | Timeline active |
| error | output | 1 | Sticky underrun fault |

## Verification
A wrong countdown value shows up as an instr_ready pulse that comes one or more cycles early or late relative to the previous acceptance. A too-short count can also fault at once, with error rising in the cycle after the expected acceptance. A wrong latched opcode or condition shows up one cycle after acceptance, as a missing or extra strobe or as wrong indices. A stale armed event in the wait logic shows up as an acceptance that comes before the matching trigger or sync, or never comes, and is visible within one duration of the event. A broken fault latch shows up as error falling, or as a strobe appearing while error is high.

// File: rtl/rt_timeline_pkg.sv
package rt_timeline_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_UPD       = 4'd1;
  localparam logic [OPC_W-1:0] OPC_PLAY      = 4'd2;
  localparam logic [OPC_W-1:0] OPC_ACQ_SQ    = 4'd3;
  localparam logic [OPC_W-1:0] OPC_ACQ_WT    = 4'd4;
  localparam logic [OPC_W-1:0] OPC_ACQ_TTL   = 4'd5;
  localparam logic [OPC_W-1:0] OPC_WAIT      = 4'd6;
  localparam logic [OPC_W-1:0] OPC_WAIT_TRIG = 4'd7;
  localparam logic [OPC_W-1:0] OPC_WAIT_SYNC = 4'd8;
  localparam logic [OPC_W-1:0] OPC_STOP      = 4'd9;

  localparam logic [1:0] KIND_SQUARE   = 2'd0;
  localparam logic [1:0] KIND_WEIGHTED = 2'd1;
  localparam logic [1:0] KIND_TTL      = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_BLOCK = 2'd2,
    ST_FAULT = 2'd3
  } tl_state_e;

endpackage

// File: rtl/rt_dur_timer.sv
module rt_dur_timer #(
  parameter int DUR_W   = 16,
  parameter int MIN_DUR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [DUR_W-1:0] dur_raw,
  output logic             expire
);

  localparam logic [DUR_W-1:0] MIN_V = DUR_W'(MIN_DUR);
  localparam logic [DUR_W-1:0] ONE_V = DUR_W'(1);

  logic [DUR_W-1:0] cnt_q;
  logic [DUR_W-1:0] eff_dur;

  // short durations are raised to the minimum at load time
  assign eff_dur = (dur_raw < MIN_V) ? MIN_V : dur_raw;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= eff_dur;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE_V;
    end
  end

  // a load in cycle t makes this true in cycle t + eff_dur
  assign expire = (cnt_q == ONE_V);

endmodule

// File: rtl/rt_event_gate.sv
module rt_event_gate #(
  parameter int TADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               arm_trig,
  input  logic               arm_sync,
  input  logic [TADDR_W-1:0] want_addr,
  input  logic               trig_valid,
  input  logic [TADDR_W-1:0] trig_addr,
  input  logic               sync_done,
  output logic               hit
);

  logic               trig_armed_q;
  logic               sync_armed_q;
  logic [TADDR_W-1:0] addr_q;

  assign hit = (trig_armed_q && trig_valid && (trig_addr == addr_q)) ||
               (sync_armed_q && sync_done);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      trig_armed_q <= 1'b0;
      sync_armed_q <= 1'b0;
      addr_q       <= '0;
    end else if (arm_trig || arm_sync) begin
      trig_armed_q <= arm_trig;
      sync_armed_q <= arm_sync;
      addr_q       <= want_addr;
    end else if (hit) begin
      trig_armed_q <= 1'b0;
      sync_armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rt_strobe_regs.sv
module rt_strobe_regs
  import rt_timeline_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [OPC_W-1:0] op,
  input  logic [IDX_W-1:0] arg0,
  input  logic [IDX_W-1:0] arg1,
  output logic             upd_stb,
  output logic             play_stb,
  output logic [IDX_W-1:0] play_idx0,
  output logic [IDX_W-1:0] play_idx1,
  output logic             acq_stb,
  output logic [IDX_W-1:0] acq_idx,
  output logic [IDX_W-1:0] acq_bin,
  output logic [1:0]       acq_kind
);

  logic       is_play;
  logic       is_acq;
  logic [1:0] kind_d;

  always_comb begin
    is_play = 1'b0;
    is_acq  = 1'b0;
    kind_d  = KIND_SQUARE;
    case (op)
      OPC_PLAY:    is_play = 1'b1;
      OPC_ACQ_SQ:  begin is_acq = 1'b1; kind_d = KIND_SQUARE;   end
      OPC_ACQ_WT:  begin is_acq = 1'b1; kind_d = KIND_WEIGHTED; end
      OPC_ACQ_TTL: begin is_acq = 1'b1; kind_d = KIND_TTL;      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_stb   <= 1'b0;
      play_stb  <= 1'b0;
      acq_stb   <= 1'b0;
      play_idx0 <= '0;
      play_idx1 <= '0;
      acq_idx   <= '0;
      acq_bin   <= '0;
      acq_kind  <= KIND_SQUARE;
    end else begin
      upd_stb  <= fire && (op == OPC_UPD || is_play || is_acq);
      play_stb <= fire && is_play;
      acq_stb  <= fire && is_acq;
      if (fire && is_play) begin
        play_idx0 <= arg0;
        play_idx1 <= arg1;
      end
      if (fire && is_acq) begin
        acq_idx  <= arg0;
        acq_bin  <= arg1;
        acq_kind <= kind_d;
      end
    end
  end

endmodule

// File: rtl/rt_timeline.sv
module rt_timeline
  import rt_timeline_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int DUR_W   = 16,
  parameter int TADDR_W = 4,
  parameter int MIN_DUR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [3:0]         instr_op,
  input  logic [IDX_W-1:0]   instr_arg0,
  input  logic [IDX_W-1:0]   instr_arg1,
  input  logic [DUR_W-1:0]   instr_dur,
  input  logic               cond_pass,
  input  logic [DUR_W-1:0]   cond_else_dur,
  input  logic               trig_valid,
  input  logic [TADDR_W-1:0] trig_addr,
  input  logic               sync_done,
  output logic               upd_stb,
  output logic               play_stb,
  output logic [IDX_W-1:0]   play_idx0,
  output logic [IDX_W-1:0]   play_idx1,
  output logic               acq_stb,
  output logic [IDX_W-1:0]   acq_idx,
  output logic [IDX_W-1:0]   acq_bin,
  output logic [1:0]         acq_kind,
  output logic               running,
  output logic               error
);

  tl_state_e        state_q, state_n;
  logic             stop_q;
  logic [DUR_W-1:0] held_dur_q;

  logic             expire;
  logic             hit;
  logic             take;
  logic             exec;
  logic             blocking;
  logic             tmr_load;
  logic [DUR_W-1:0] tmr_dur;
  logic             arm_trig;
  logic             arm_sync;

  assign exec     = cond_pass;
  assign take     = instr_valid &&
                    ((state_q == ST_IDLE) ||
                     (state_q == ST_RUN && expire && !stop_q));
  assign blocking = exec && (instr_op == OPC_WAIT_TRIG || instr_op == OPC_WAIT_SYNC);
  assign arm_trig = take && exec && (instr_op == OPC_WAIT_TRIG);
  assign arm_sync = take && exec && (instr_op == OPC_WAIT_SYNC);

  assign tmr_load = (take && !blocking) || (state_q == ST_BLOCK && hit);
  assign tmr_dur  = (state_q == ST_BLOCK) ? held_dur_q
                  : (exec ? instr_dur : cond_else_dur);

  assign instr_ready = take;

  rt_dur_timer #(
    .DUR_W   (DUR_W),
    .MIN_DUR (MIN_DUR)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (state_q == ST_FAULT),
    .load    (tmr_load),
    .dur_raw (tmr_dur),
    .expire  (expire)
  );

  rt_event_gate #(
    .TADDR_W (TADDR_W)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .clear      (state_q == ST_FAULT),
    .arm_trig   (arm_trig),
    .arm_sync   (arm_sync),
    .want_addr  (instr_arg0[TADDR_W-1:0]),
    .trig_valid (trig_valid),
    .trig_addr  (trig_addr),
    .sync_done  (sync_done),
    .hit        (hit)
  );

  rt_strobe_regs #(
    .IDX_W (IDX_W)
  ) u_strobes (
    .clk       (clk),
    .rst       (rst),
    .fire      (take && exec),
    .op        (instr_op),
    .arg0      (instr_arg0),
    .arg1      (instr_arg1),
    .upd_stb   (upd_stb),
    .play_stb  (play_stb),
    .play_idx0 (play_idx0),
    .play_idx1 (play_idx1),
    .acq_stb   (acq_stb),
    .acq_idx   (acq_idx),
    .acq_bin   (acq_bin),
    .acq_kind  (acq_kind)
  );

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE: begin
        if (take) state_n = blocking ? ST_BLOCK : ST_RUN;
      end
      ST_RUN: begin
        if (expire) begin
          if (take)        state_n = blocking ? ST_BLOCK : ST_RUN;
          else if (stop_q) state_n = ST_IDLE;
          else             state_n = ST_FAULT;
        end
      end
      ST_BLOCK: begin
        if (hit) state_n = ST_RUN;
      end
      default: state_n = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      stop_q     <= 1'b0;
      held_dur_q <= '0;
      running    <= 1'b0;
      error      <= 1'b0;
    end else begin
      state_q <= state_n;
      running <= (state_n == ST_RUN) || (state_n == ST_BLOCK);
      error   <= (state_n == ST_FAULT);
      if (take) begin
        stop_q     <= exec && (instr_op == OPC_STOP);
        held_dur_q <= instr_dur;
      end
    end
  end

endmodule

// File: rtl/rt_timeline_checker.sv
module rt_timeline_checker #(
  parameter int MIN_DUR = 4
) (
  input logic clk,
  input logic rst,
  input logic instr_valid,
  input logic instr_ready,
  input logic upd_stb,
  input logic play_stb,
  input logic acq_stb,
  input logic running,
  input logic error
);

  localparam int GW = $clog2(MIN_DUR + 2);
  localparam logic [GW-1:0] MINV = GW'(MIN_DUR);

  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          take;

  assign take = instr_valid && instr_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (take) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else if (gap_q < MINV) begin
      gap_q <= gap_q + GW'(1);
    end
  end

  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    take |=> running); // R1

  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst)
    (take && seen_q) |-> (gap_q >= MINV)); // R3

  AST_STB_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (rst)
    upd_stb |-> $past(take)); // R4

  AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
    !(play_stb && acq_stb)); // R4

  AST_PLAY_UPDATES: assert property (@(posedge clk) disable iff (rst)
    play_stb |-> upd_stb); // R5

  AST_ACQ_UPDATES: assert property (@(posedge clk) disable iff (rst)
    acq_stb |-> upd_stb); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    error |=> error); // R10

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    error |-> (!upd_stb && !play_stb && !acq_stb && !instr_ready)); // R10

  AST_RUN_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(running && error)); // R10

endmodule

bind rt_timeline rt_timeline_checker #(.MIN_DUR(MIN_DUR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .upd_stb     (upd_stb),
  .play_stb    (play_stb),
  .acq_stb     (acq_stb),
  .running     (running),
  .error       (error)
);

// File: tb/rt_timeline_bench.sv
module rt_timeline_bench;

  localparam int IDX_W   = 6;
  localparam int DUR_W   = 16;
  localparam int TADDR_W = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               instr_valid = 1'b0;
  logic               instr_ready;
  logic [3:0]         instr_op = '0;
  logic [IDX_W-1:0]   instr_arg0 = '0;
  logic [IDX_W-1:0]   instr_arg1 = '0;
  logic [DUR_W-1:0]   instr_dur = '0;
  logic               cond_pass = 1'b0;
  logic [DUR_W-1:0]   cond_else_dur = '0;
  logic               trig_valid = 1'b0;
  logic [TADDR_W-1:0] trig_addr = '0;
  logic               sync_done = 1'b0;
  logic               upd_stb, play_stb, acq_stb, running, error;
  logic [IDX_W-1:0]   play_idx0, play_idx1, acq_idx, acq_bin;
  logic [1:0]         acq_kind;

  rt_timeline #(.IDX_W(IDX_W), .DUR_W(DUR_W), .TADDR_W(TADDR_W)) u_rt_timeline (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_arg0(instr_arg0), .instr_arg1(instr_arg1),
    .instr_dur(instr_dur), .cond_pass(cond_pass), .cond_else_dur(cond_else_dur),
    .trig_valid(trig_valid), .trig_addr(trig_addr), .sync_done(sync_done),
    .upd_stb(upd_stb), .play_stb(play_stb), .play_idx0(play_idx0),
    .play_idx1(play_idx1), .acq_stb(acq_stb), .acq_idx(acq_idx),
    .acq_bin(acq_bin), .acq_kind(acq_kind), .running(running), .error(error)
  );

  always #4 clk = ~clk;

  int q_op[64], q_a0[64], q_a1[64], q_dur[64], q_else[64];
  bit q_cond[64];
  int pop_cyc[64];
  int qn = 0, head = 0, hold_idx = -1;
  int cyc = 0, base = 0;
  bit run_log[2048], err_log[2048];
  int trig_idx = -1, sync_idx = -1, trig_bad_at = -1, trig_ok_at = -1, sync_at = -1;
  int trig_good_addr = 5;
  bit exp_upd = 0, exp_play = 0, exp_acq = 0;
  int exp_i0 = 0, exp_i1 = 0, exp_kind = 0;
  int n_upd = 0, n_play = 0, n_acq = 0;
  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int eff(input int d);
    return (d < 4) ? 4 : d;
  endfunction

  function automatic bit rlog(input int c);
    if (c - base >= 0 && c - base < 2048) return run_log[c - base];
    return 1'b0;
  endfunction

  function automatic bit elog(input int c);
    if (c - base >= 0 && c - base < 2048) return err_log[c - base];
    return 1'b0;
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // drive / monitor loop: everything here happens at the falling edge
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (cyc - base >= 0 && cyc - base < 2048) begin
        run_log[cyc - base] = running;
        err_log[cyc - base] = error;
      end
      if (exp_upd || upd_stb)
        check(upd_stb == exp_upd, "R4 update strobe", int'(upd_stb), int'(exp_upd));
      if (exp_play || play_stb) begin
        check(play_stb == exp_play, "R5 play strobe", int'(play_stb), int'(exp_play));
        if (exp_play && play_stb) begin
          check(int'(play_idx0) == exp_i0, "R5 play index 0", int'(play_idx0), exp_i0);
          check(int'(play_idx1) == exp_i1, "R5 play index 1", int'(play_idx1), exp_i1);
        end
      end
      if (exp_acq || acq_stb) begin
        check(acq_stb == exp_acq, "R6 acquire strobe", int'(acq_stb), int'(exp_acq));
        if (exp_acq && acq_stb) begin
          check(int'(acq_idx) == exp_i0, "R6 acquire index", int'(acq_idx), exp_i0);
          check(int'(acq_bin) == exp_i1, "R6 acquire bin", int'(acq_bin), exp_i1);
          check(int'(acq_kind) == exp_kind, "R6 acquire kind", int'(acq_kind), exp_kind);
        end
      end
      n_upd  += int'(upd_stb);
      n_play += int'(play_stb);
      n_acq  += int'(acq_stb);
    end
    instr_valid = !rst && head < qn && head != hold_idx;
    if (head < qn) begin
      instr_op      = 4'(q_op[head]);
      instr_arg0    = IDX_W'(q_a0[head]);
      instr_arg1    = IDX_W'(q_a1[head]);
      instr_dur     = DUR_W'(q_dur[head]);
      cond_pass     = q_cond[head];
      cond_else_dur = DUR_W'(q_else[head]);
    end else begin
      instr_op = '0; instr_arg0 = '0; instr_arg1 = '0;
      instr_dur = '0; cond_pass = 1'b0; cond_else_dur = '0;
    end
    trig_valid = !rst && (cyc == trig_bad_at || cyc == trig_ok_at);
    trig_addr  = (cyc == trig_ok_at) ? TADDR_W'(trig_good_addr) : TADDR_W'(trig_good_addr + 3);
    sync_done  = !rst && (cyc == sync_at);
    #1;
    exp_upd = 0; exp_play = 0; exp_acq = 0;
    if (instr_valid && instr_ready) begin
      pop_cyc[head] = cyc;
      if (q_cond[head]) begin
        exp_upd  = (q_op[head] >= 1 && q_op[head] <= 5);
        exp_play = (q_op[head] == 2);
        exp_acq  = (q_op[head] >= 3 && q_op[head] <= 5);
        exp_i0   = q_a0[head] % 64;
        exp_i1   = q_a1[head] % 64;
        exp_kind = q_op[head] - 3;
      end
      if (head == trig_idx) begin trig_bad_at = cyc + 3; trig_ok_at = cyc + 7; end
      if (head == sync_idx) sync_at = cyc + 6;
      head++;
    end
  end

  task automatic begin_reset();
    @(posedge clk); #2;
    rst = 1'b1;
    qn = 0; head = 0; hold_idx = -1;
    trig_idx = -1; sync_idx = -1; trig_bad_at = -1; trig_ok_at = -1; sync_at = -1;
    n_upd = 0; n_play = 0; n_acq = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(running == 1'b0, "R1 running in reset", int'(running), 0);
    check(error == 1'b0, "R1 error in reset", int'(error), 0);
    check(!upd_stb && !play_stb && !acq_stb, "R1 strobes in reset",
          int'(upd_stb) + int'(play_stb) + int'(acq_stb), 0);
  endtask

  task automatic release_rst();
    @(posedge clk); #2;
    base = cyc;
    rst = 1'b0;
  endtask

  task automatic push(input int op, input int a0, input int a1, input int d,
                      input bit c, input int el);
    q_op[qn] = op; q_a0[qn] = a0; q_a1[qn] = a1; q_dur[qn] = d;
    q_cond[qn] = c; q_else[qn] = el;
    qn++;
  endtask

  task automatic drain(input int extra);
    int t = 0;
    while (head < qn && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (extra) @(negedge clk);
  endtask

  function automatic int opsel(input int k);
    case (k)
      0: return 1; 1: return 2; 2: return 3; 3: return 4;
      4: return 5; 5: return 6; default: return 12;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int e_upd, e_play, e_acq, ps, p1, frozen;
    // Scenario A: sweep of opcodes and durations 0..8, then stop
    begin_reset();
    e_upd = 0; e_play = 0; e_acq = 0;
    for (int k = 0; k < 27; k++) begin
      push(opsel(k % 7), (k * 5) % 64, (k * 3 + 1) % 64, k % 9, 1'b1, 0);
      if (opsel(k % 7) <= 5) e_upd++;
      if (opsel(k % 7) == 2) e_play++;
      if (opsel(k % 7) >= 3 && opsel(k % 7) <= 5) e_acq++;
    end
    push(9, 0, 0, 5, 1'b1, 0);
    release_rst();
    drain(12);
    check(rlog(pop_cyc[0] + 1) == 1'b1, "R1 running after first accept",
          int'(rlog(pop_cyc[0] + 1)), 1);
    for (int k = 1; k < qn; k++) begin
      if (q_dur[k-1] < 4)
        check(pop_cyc[k] - pop_cyc[k-1] == 4, "R3 clamped spacing",
              pop_cyc[k] - pop_cyc[k-1], 4);
      else
        check(pop_cyc[k] - pop_cyc[k-1] == q_dur[k-1], "R2 spacing",
              pop_cyc[k] - pop_cyc[k-1], q_dur[k-1]);
    end
    check(n_upd == e_upd, "R12 update count", n_upd, e_upd);
    check(n_play == e_play, "R12 play count", n_play, e_play);
    check(n_acq == e_acq, "R12 acquire count", n_acq, e_acq);
    ps = pop_cyc[qn-1];
    check(rlog(ps + 5) == 1'b1, "R11 running through stop", int'(rlog(ps + 5)), 1);
    check(rlog(ps + 6) == 1'b0, "R11 running drops after stop", int'(rlog(ps + 6)), 0);
    check(elog(ps + 6) == 1'b0, "R11 no error after stop", int'(elog(ps + 6)), 0);

    // Scenario B: suppressed instructions
    begin_reset();
    push(1, 1, 2, 5, 1'b1, 0);
    push(2, 9, 10, 10, 1'b0, 6);
    push(7, 5, 0, 9, 1'b0, 2);
    push(3, 11, 12, 4, 1'b1, 0);
    push(9, 0, 0, 4, 1'b1, 0);
    release_rst();
    drain(10);
    check(pop_cyc[1] - pop_cyc[0] == 5, "R2 spacing", pop_cyc[1] - pop_cyc[0], 5);
    check(pop_cyc[2] - pop_cyc[1] == 6, "R9 else-duration", pop_cyc[2] - pop_cyc[1], 6);
    check(pop_cyc[3] - pop_cyc[2] == 4, "R9 suppressed wait clamps else", pop_cyc[3] - pop_cyc[2], 4);
    check(n_play == 0, "R9 no play when suppressed", n_play, 0);
    check(n_upd == 2, "R9 update count", n_upd, 2);
    check(n_acq == 1, "R9 acquire count", n_acq, 1);

    // Scenario C: trigger and sync waits
    begin_reset();
    trig_good_addr = 5;
    push(1, 0, 0, 4, 1'b1, 0);
    push(7, 5, 0, 6, 1'b1, 0);
    push(2, 7, 8, 4, 1'b1, 0);
    push(8, 0, 0, 5, 1'b1, 0);
    push(9, 0, 0, 4, 1'b1, 0);
    trig_idx = 1; sync_idx = 3;
    release_rst();
    drain(10);
    check(pop_cyc[1] - pop_cyc[0] == 4, "R2 spacing", pop_cyc[1] - pop_cyc[0], 4);
    check(pop_cyc[2] - pop_cyc[1] == 13, "R7 trigger wait", pop_cyc[2] - pop_cyc[1], 13);
    check(rlog(pop_cyc[1] + 5) == 1'b1, "R7 running while blocked", int'(rlog(pop_cyc[1] + 5)), 1);
    check(pop_cyc[4] - pop_cyc[3] == 11, "R8 sync wait", pop_cyc[4] - pop_cyc[3], 11);
    check(n_play == 1, "R7 play after trigger", n_play, 1);

    // Scenario D: underrun fault
    begin_reset();
    push(1, 0, 0, 4, 1'b1, 0);
    push(2, 3, 4, 6, 1'b1, 0);
    push(3, 1, 2, 4, 1'b1, 0);
    hold_idx = 2;
    release_rst();
    repeat (30) @(negedge clk);
    p1 = pop_cyc[1];
    check(elog(p1 + 6) == 1'b0, "R10 no error before expiry", int'(elog(p1 + 6)), 0);
    check(elog(p1 + 7) == 1'b1, "R10 error after underrun", int'(elog(p1 + 7)), 1);
    check(rlog(p1 + 7) == 1'b0, "R10 running drops on fault", int'(rlog(p1 + 7)), 0);
    frozen = n_upd;
    hold_idx = -1;
    repeat (30) @(negedge clk);
    check(head == 2, "R10 nothing accepted after fault", head, 2);
    check(n_upd == frozen, "R10 no strobe after fault", n_upd, frozen);
    check(error == 1'b1, "R10 error sticky", int'(error), 1);

    // reset clears the fault
    begin_reset();
    release_rst();
    repeat (5) @(negedge clk);
    check(error == 1'b0, "R1 error cleared by reset", int'(error), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule